// File: doc/BRIEF.md
# Four-Bit Character Display Byte Sender

This block moves 8-bit command and data bytes to a character display module over a 4-bit bus. A client offers a byte with a valid/ready handshake, together with a register-select bit that marks it as a command (0) or as display data (1). The block puts the high half of the byte on the bus first and strobes the enable line. It waits the inter-half gap, then puts the low half on the bus and strobes again. It then keeps its ready output low for a fixed recovery wait, so the display can finish the operation. All timing is counted in cycles of a 50 MHz clock, so no busy-flag readback is needed.

The recovery wait depends on the byte. A Clear Display command (register-select 0, byte 0x01) gets a much longer wait than any other byte. The display is only ever written, so the read/write line stays low. A single-nibble mode serves a power-up sequencer. It sends one strobe carrying the low four bits of the input byte and returns ready shortly after. The delay that follows is the caller's job.

Top module: `lcd_nibble_xfer`

## Requirements
- R1: `lcd_rw` is 0 in every cycle.
- R2: While reset is high and right after it, `lcd_en`=0, `lcd_d`=0, `lcd_rs`=0 and `in_ready`=1.
- R3: In byte mode (`in_nib_mode`=0), the first strobe carries `in_data[7:4]` on `lcd_d` and the second carries `in_data[3:0]`. `lcd_rs` equals the accepted `in_rs` for the whole transfer.
- R4: `lcd_d` and `lcd_rs` take their new value exactly SETUP_CYC cycles before each rising edge of `lcd_en`, and stay unchanged across that interval.
- R5: Each strobe keeps `lcd_en` high for exactly PULSE_CYC cycles.
- R6: Between the two strobes of one byte, `lcd_en` is low for exactly NIB_GAP_CYC cycles. The low nibble appears SETUP_CYC cycles before the second rise.
- R7: After the second strobe of a byte falls, `in_ready` stays low for BYTE_GAP_CYC more cycles and then returns to 1.
- R8: A byte with `in_rs`=0 and value 0x01 gets CLEAR_GAP_CYC in place of BYTE_GAP_CYC. The same value with `in_rs`=1 gets BYTE_GAP_CYC.
- R9: In nibble mode (`in_nib_mode`=1), exactly one strobe is sent, carrying `in_data[3:0]`; `in_data[7:4]` is ignored. `in_ready` returns HOLD_CYC cycles after that strobe falls.
- R10: `lcd_d` and `lcd_rs` do not change while `lcd_en` is high, nor in the cycle after it falls.
- R11: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 from the next cycle on. Input values presented while `in_ready` is 0 have no effect on the bus.
- R12: `lcd_en` is never 1 while `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Client offers a byte |
| in_ready | output | 1 | Block can accept a byte this cycle |
| in_data | input | 8 | Byte to send (low four bits only in nibble mode) |
| in_rs | input | 1 | Register select for the byte: 0 command, 1 data |
| in_nib_mode | input | 1 | 1: send a single nibble strobe |
| lcd_d | output | 4 | Display data bus (upper four lines) |
| lcd_rs | output | 1 | Display register select |
| lcd_rw | output | 1 | Display read/write, held low |
| lcd_en | output | 1 | Display enable strobe |

## Verification
The bench aims at the cycle counts around each strobe. A design that is off by one in setup, pulse or gap shows an enable edge one cycle early or late. One that swaps the halves shows the low nibble first. The recovery wait is measured for 0x01 sent as a command and as data. A design that decoded the clear case from the byte alone, or missed it, would return ready about 700 cycles early or late. A valid held high through a busy period, with its data changing, shows whether anything leaks onto the bus before ready returns. Nibble mode with a nonzero upper half catches a design that sends the wrong half or a second strobe.

// File: rtl/lcd_xfer_pkg.sv
package lcd_xfer_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;

  // command byte whose execution needs the long recovery wait
  localparam logic [BYTE_W-1:0] CLEAR_CMD = 8'h01;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_GAP,
    PH_WAIT
  } phase_t;

endpackage

// File: rtl/lcd_xfer_timer.sv
module lcd_xfer_timer #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/lcd_xfer_seq.sv
module lcd_xfer_seq
  import lcd_xfer_pkg::*;
#(
  parameter int unsigned SETUP_CYC     = 2,
  parameter int unsigned PULSE_CYC     = 12,
  parameter int unsigned NIB_GAP_CYC   = 50,
  parameter int unsigned HOLD_CYC      = 1,
  parameter int unsigned BYTE_GAP_CYC  = 2000,
  parameter int unsigned CLEAR_GAP_CYC = 82000,
  parameter int unsigned CNT_W         = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_rs,
  input  logic              in_nib_mode,
  output logic [NIB_W-1:0]  lcd_d,
  output logic              lcd_rs,
  output logic              lcd_en,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  input  logic              tmr_expired
);

  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_GAP   = CNT_W'(NIB_GAP_CYC - SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_BYTE  = CNT_W'(BYTE_GAP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_CLEAR = CNT_W'(CLEAR_GAP_CYC - 1);

  phase_t             phase;
  logic [NIB_W-1:0]   lo_nib;
  logic               lo_pend;
  logic               nib_q;
  logic               clear_q;
  logic               accept;

  assign accept = in_valid && in_ready;

  // timer reload for the phase being entered
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase)
      PH_IDLE: begin
        tmr_load = accept;
        tmr_val  = LD_SETUP;
      end
      PH_SETUP: begin
        tmr_load = tmr_expired;
        tmr_val  = LD_PULSE;
      end
      PH_STROBE: begin
        tmr_load = tmr_expired;
        if (lo_pend)      tmr_val = LD_GAP;
        else if (nib_q)   tmr_val = LD_HOLD;
        else if (clear_q) tmr_val = LD_CLEAR;
        else              tmr_val = LD_BYTE;
      end
      PH_GAP: begin
        tmr_load = tmr_expired;
        tmr_val  = LD_SETUP;
      end
      default: begin
        tmr_load = 1'b0;
        tmr_val  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      in_ready <= 1'b1;
      lcd_en   <= 1'b0;
      lcd_d    <= '0;
      lcd_rs   <= 1'b0;
      lo_nib   <= '0;
      lo_pend  <= 1'b0;
      nib_q    <= 1'b0;
      clear_q  <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            lcd_d    <= in_nib_mode ? in_data[NIB_W-1:0] : in_data[BYTE_W-1:NIB_W];
            lcd_rs   <= in_rs;
            lo_nib   <= in_data[NIB_W-1:0];
            lo_pend  <= !in_nib_mode;
            nib_q    <= in_nib_mode;
            clear_q  <= !in_rs && (in_data == CLEAR_CMD);
            in_ready <= 1'b0;
            phase    <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (tmr_expired) begin
            lcd_en <= 1'b1;
            phase  <= PH_STROBE;
          end
        end
        PH_STROBE: begin
          if (tmr_expired) begin
            lcd_en <= 1'b0;
            phase  <= lo_pend ? PH_GAP : PH_WAIT;
          end
        end
        PH_GAP: begin
          if (tmr_expired) begin
            lcd_d   <= lo_nib;
            lo_pend <= 1'b0;
            phase   <= PH_SETUP;
          end
        end
        PH_WAIT: begin
          if (tmr_expired) begin
            in_ready <= 1'b1;
            phase    <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lcd_nibble_xfer.sv
module lcd_nibble_xfer
  import lcd_xfer_pkg::*;
#(
  parameter int unsigned SETUP_CYC     = 2,
  parameter int unsigned PULSE_CYC     = 12,
  parameter int unsigned NIB_GAP_CYC   = 50,
  parameter int unsigned HOLD_CYC      = 1,
  parameter int unsigned BYTE_GAP_CYC  = 2000,
  parameter int unsigned CLEAR_GAP_CYC = 82000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_rs,
  input  logic              in_nib_mode,
  output logic [NIB_W-1:0]  lcd_d,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic              lcd_en
);

  localparam int unsigned MAX_A   = (PULSE_CYC > NIB_GAP_CYC) ? PULSE_CYC : NIB_GAP_CYC;
  localparam int unsigned MAX_B   = (BYTE_GAP_CYC > CLEAR_GAP_CYC) ? BYTE_GAP_CYC : CLEAR_GAP_CYC;
  localparam int unsigned MAX_C   = (HOLD_CYC > SETUP_CYC) ? HOLD_CYC : SETUP_CYC;
  localparam int unsigned MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_ALL = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int unsigned CNT_W   = $clog2(MAX_ALL + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;

  // write-only display: never request a read
  assign lcd_rw = 1'b0;

  lcd_xfer_seq #(
    .SETUP_CYC    (SETUP_CYC),
    .PULSE_CYC    (PULSE_CYC),
    .NIB_GAP_CYC  (NIB_GAP_CYC),
    .HOLD_CYC     (HOLD_CYC),
    .BYTE_GAP_CYC (BYTE_GAP_CYC),
    .CLEAR_GAP_CYC(CLEAR_GAP_CYC),
    .CNT_W        (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .in_rs      (in_rs),
    .in_nib_mode(in_nib_mode),
    .lcd_d      (lcd_d),
    .lcd_rs     (lcd_rs),
    .lcd_en     (lcd_en),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .tmr_expired(tmr_expired)
  );

  lcd_xfer_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

endmodule

// File: rtl/lcd_nibble_xfer_chk.sv
module lcd_nibble_xfer_chk #(
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned PULSE_CYC = 12
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic [3:0] lcd_d,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic       lcd_en
);

  localparam int unsigned CW = 16;

  logic [3:0]    d_q;
  logic          rs_q;
  logic          en_q;
  logic [CW-1:0] stab_cnt;
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q      <= '0;
      rs_q     <= 1'b0;
      en_q     <= 1'b0;
      stab_cnt <= '0;
      hi_cnt   <= '0;
    end else begin
      d_q  <= lcd_d;
      rs_q <= lcd_rs;
      en_q <= lcd_en;
      if (lcd_d != d_q || lcd_rs != rs_q) stab_cnt <= '0;
      else if (stab_cnt != '1)            stab_cnt <= stab_cnt + 1'b1;
      hi_cnt <= lcd_en ? hi_cnt + 1'b1 : '0;
    end
  end

  // R1
  rw_low_chk: assert property (@(posedge clk) disable iff (rst) lcd_rw == 1'b0);

  // R4
  setup_window_chk: assert property (@(posedge clk) disable iff (rst)
    (lcd_en && !en_q) |-> (lcd_d == d_q && lcd_rs == rs_q && (32'(stab_cnt) + 1 >= SETUP_CYC)));

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    (!lcd_en && en_q) |-> (32'(hi_cnt) == PULSE_CYC));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    lcd_en |=> ($stable(lcd_d) && $stable(lcd_rs)));

  // R11
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R12
  no_strobe_when_ready_chk: assert property (@(posedge clk) disable iff (rst)
    lcd_en |-> !in_ready);

endmodule

bind lcd_nibble_xfer lcd_nibble_xfer_chk #(
  .SETUP_CYC(SETUP_CYC),
  .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .lcd_d   (lcd_d),
  .lcd_rs  (lcd_rs),
  .lcd_rw  (lcd_rw),
  .lcd_en  (lcd_en)
);

// File: tb/tb_lcd_nibble_xfer.sv
module tb_lcd_nibble_xfer;

  localparam int S  = 2;
  localparam int P  = 12;
  localparam int G  = 50;
  localparam int H  = 1;
  localparam int BG = 200;
  localparam int CG = 900;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_rs = 1'b0;
  logic       in_nib_mode = 1'b0;
  logic       in_ready;
  logic [3:0] lcd_d;
  logic       lcd_rs;
  logic       lcd_rw;
  logic       lcd_en;

  always #10 clk = ~clk;

  lcd_nibble_xfer #(
    .SETUP_CYC(S), .PULSE_CYC(P), .NIB_GAP_CYC(G), .HOLD_CYC(H),
    .BYTE_GAP_CYC(BG), .CLEAR_GAP_CYC(CG)
  ) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_rs(in_rs), .in_nib_mode(in_nib_mode),
    .lcd_d(lcd_d), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en)
  );

  typedef struct packed {
    logic       en;
    logic [3:0] d;
    logic       rs;
    logic       rdy;
  } exp_t;

  exp_t  q[$];
  exp_t  cur;
  int    checks = 0;
  int    fails  = 0;
  string tag    = "R2";

  task automatic chk(input bit ok, input string t, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, expv);
    end
  endtask

  task automatic push(input int n, input logic en, input logic [3:0] d, input logic rs);
    for (int i = 0; i < n; i++) q.push_back('{en: en, d: d, rs: rs, rdy: 1'b0});
  endtask

  // expected outputs after each edge, starting with the accept edge
  task automatic plan(input logic [7:0] dat, input logic r, input logic nb);
    int w;
    if (nb) begin
      push(S, 1'b0, dat[3:0], r);
      push(P, 1'b1, dat[3:0], r);
      push(H, 1'b0, dat[3:0], r);
    end else begin
      w = (!r && dat == 8'h01) ? CG : BG;
      push(S,     1'b0, dat[7:4], r);
      push(P,     1'b1, dat[7:4], r);
      push(G - S, 1'b0, dat[7:4], r);
      push(S,     1'b0, dat[3:0], r);
      push(P,     1'b1, dat[3:0], r);
      push(w,     1'b0, dat[3:0], r);
    end
  endtask

  task automatic compare();
    if (q.size() > 0) begin
      cur = q.pop_front();
    end else begin
      cur.en  = 1'b0;
      cur.rdy = 1'b1;
    end
    chk(lcd_rw === 1'b0,     "R1", "rw",    int'(lcd_rw),   0);
    chk(lcd_en === cur.en,   tag,  "en",    int'(lcd_en),   int'(cur.en));
    chk(lcd_d === cur.d,     tag,  "d",     int'(lcd_d),    int'(cur.d));
    chk(lcd_rs === cur.rs,   tag,  "rs",    int'(lcd_rs),   int'(cur.rs));
    chk(in_ready === cur.rdy, tag, "ready", int'(in_ready), int'(cur.rdy));
  endtask

  task automatic tick(input logic v, input logic [7:0] dat, input logic r, input logic nb);
    in_valid    = v;
    in_data     = dat;
    in_rs       = r;
    in_nib_mode = nb;
    if (v && cur.rdy) plan(dat, r, nb);
    @(negedge clk);
    compare();
  endtask

  task automatic drain();
    while (q.size() > 0 || !cur.rdy) tick(1'b0, 8'hA5, 1'b1, 1'b0);
  endtask

  // one transfer, measuring how long ready stays low
  task automatic xfer(input logic [7:0] dat, input logic r, input logic nb,
                      input string t, input int exp_busy);
    int busy = 0;
    tag = t;
    tick(1'b1, dat, r, nb);
    if (in_ready === 1'b0) busy++;
    while (q.size() > 0) begin
      tick(1'b0, 8'h5C, ~r, ~nb);
      if (in_ready === 1'b0) busy++;
    end
    tick(1'b0, 8'h00, 1'b0, 1'b0);
    chk(busy == exp_busy, t, "busy_cycles", busy, exp_busy);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    cur = '{en: 1'b0, d: 4'h0, rs: 1'b0, rdy: 1'b1};
    repeat (3) @(negedge clk);
    // R2: state while reset is held
    chk(lcd_en === 1'b0,   "R2", "en",    int'(lcd_en),   0);
    chk(lcd_d === 4'h0,    "R2", "d",     int'(lcd_d),    0);
    chk(lcd_rs === 1'b0,   "R2", "rs",    int'(lcd_rs),   0);
    chk(in_ready === 1'b1, "R2", "ready", int'(in_ready), 1);
    rst = 1'b0;
    tag = "R2";
    repeat (3) tick(1'b0, 8'h00, 1'b0, 1'b0);

    // R3 R4 R5 R6 R7: data byte, normal recovery
    xfer(8'h41, 1'b1, 1'b0, "R3 R4 R5 R6 R7", 2*P + S + G + BG);
    // R3 R10 R12: command byte
    xfer(8'h28, 1'b0, 1'b0, "R3 R10 R12", 2*P + S + G + BG);
    // R8: clear command gets the long wait
    xfer(8'h01, 1'b0, 1'b0, "R8 clear", 2*P + S + G + CG);
    // R8: same value as data gets the normal wait
    xfer(8'h01, 1'b1, 1'b0, "R8 data", 2*P + S + G + BG);
    // R9: nibble mode, upper half ignored
    xfer(8'hE3, 1'b0, 1'b1, "R9", S + P + H);
    xfer(8'h72, 1'b1, 1'b1, "R9", S + P + H);
    // R3: extreme patterns
    xfer(8'hF0, 1'b1, 1'b0, "R3", 2*P + S + G + BG);
    xfer(8'h0F, 1'b0, 1'b0, "R3", 2*P + S + G + BG);

    // R11: valid held high while busy, data changing, nothing leaks
    tag = "R11";
    tick(1'b1, 8'h5A, 1'b1, 1'b0);
    while (q.size() > 0 || !cur.rdy) tick(1'b1, 8'hC3, 1'b0, 1'b0);
    tick(1'b1, 8'hC3, 1'b0, 1'b0);
    while (q.size() > 0) tick(1'b1, 8'h99, 1'b1, 1'b1);
    tick(1'b0, 8'h00, 1'b0, 1'b0);
    drain();
    repeat (4) tick(1'b0, 8'h00, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule